// File: doc/BRIEF.md
# Edge-Sensing GPIO Controller with Interrupt

A 32-pin general-purpose I/O block that sits on a simple word-wide register bus. Each pin has its own direction, open-drain and output-latch bit, so it can be an input, a push-pull output or an open-drain output. The block passes every pin level through a two-flop synchroniser and then compares the last two synchronised samples to find edges. Each edge sets a sticky per-pin event flag. Software clears a flag by writing a one to it.

One configuration bit per pin selects the sensing mode: falling edges only, or both rising and falling edges. The block ANDs the event flags with a per-pin mask and raises a single interrupt line while any unmasked flag is pending. In every register, pin n sits at bit (31 − n), so pin 0 is the most significant bit.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Pin n of the pin ports corresponds to bit (31 − n) of every register, so pin 0 is the most significant register bit.
- R2: The registers sit at these byte addresses: direction 0x00, open-drain 0x04, output/data 0x08, event 0x0C, mask 0x10, edge-control 0x14. Each reads back what was written to it, except event and data. Any other address reads zero, and a write to it changes nothing.
- R3: A direction bit of 1 makes the pin an output, with its output enable active. A direction bit of 0 makes it an input, with its output enable inactive.
- R4: Writing a 1 to an event bit clears that pending flag. Writing a 0 leaves the bit unchanged.
- R5: The interrupt output is high exactly while (event AND mask) is nonzero.
- R6: An edge-control bit of 1 flags only falling edges. A bit of 0 flags both rising and falling edges. A pin change becomes visible in the event register after the third rising clock edge that follows it, because of two synchroniser stages and one detection stage.
- R7: If an edge and a write-one-to-clear reach the same event bit in the same cycle, the flag stays set.
- R8: Reading the data register returns the output latch for output pins and the synchronised pin level for input pins.
- R9: With open-drain enabled on an output pin, its output enable is active only while the latch bit is 0, and the driven value is 0. The pin is therefore pulled low or released.
- R10: After reset every register reads zero, the interrupt is low, and no output enable is active.
- R11: Writing all ones to the event register and zero to the mask register leaves the interrupt low, with every flag cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the accessed register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational on address) |
| pin_in | input | 32 | Pin levels seen from the pads, index = pin number |
| pin_out | output | 32 | Value to drive on each pin, index = pin number |
| pin_oe | output | 32 | Output enable for each pin, index = pin number |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default 32 pins. At that size a full sweep is cheap: every pin is toggled one at a time under both sensing modes. That reaches the bit-reversed mapping, the three-cycle detection latency and the masking of each individual bit. Directed sequences then place a clear write in the exact cycle of an edge, mix input and output pins in the data readback, and exercise open-drain enables against computed reversed patterns.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    SEL_DIR  = 3'd0,
    SEL_OPEN = 3'd1,
    SEL_DATA = 3'd2,
    SEL_EVT  = 3'd3,
    SEL_MASK = 3'd4,
    SEL_SENSE = 3'd5,
    SEL_NONE = 3'd7
  } reg_sel_e;

  // Byte address to register select; addresses keep the word layout.
  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] addr);
    case (addr)
      5'h00:   return SEL_DIR;
      5'h04:   return SEL_OPEN;
      5'h08:   return SEL_DATA;
      5'h0C:   return SEL_EVT;
      5'h10:   return SEL_MASK;
      5'h14:   return SEL_SENSE;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] falling_only,
  output logic [N-1:0] level,
  output logic [N-1:0] edge_hit
);

  logic [N-1:0] meta_q, sync_q, prev_q;
  logic [N-1:0] rise_w, fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_w   = sync_q & ~prev_q;
  assign fall_w   = ~sync_q & prev_q;
  assign level    = sync_q;

  // Per-pin sense selection.
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_sense
      assign edge_hit[g] = fall_w[g] | (~falling_only[g] & rise_w[g]);
    end
  endgenerate

  // R6: a reported edge always coincides with a change of the synchronised level
  a_r6_edge_is_change: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit & ~(level ^ $past(level))) == '0);

  // R6: falling-only pins never report while the level is high
  a_r6_falling_only: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit & falling_only & level) == '0);

endmodule

// File: rtl/gpio_event_reg.sv
module gpio_event_reg #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] edge_hit,
  input  logic [N-1:0] clr_bits,
  input  logic [N-1:0] mask,
  output logic [N-1:0] events,
  output logic         irq
);

  logic [N-1:0] evt_q;

  // Edge wins over a simultaneous clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_q & ~clr_bits) | edge_hit;
  end

  assign events = evt_q;
  assign irq    = |(evt_q & mask);

  // R4: a cleared bit with no competing edge is zero next cycle
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (evt_q & $past(clr_bits & ~edge_hit)) == '0);

  // R7: every edge leaves its flag set
  a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (evt_q & $past(edge_hit)) == $past(edge_hit));

  // R6: a flag only rises after an edge
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (evt_q & ~$past(evt_q) & ~$past(edge_hit)) == '0);

  // R5: interrupt needs a pending unmasked flag
  a_r5_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != '0 && evt_q != '0));

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_edge_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [N-1:0]      wdata,
  input  logic [N-1:0]      level,
  input  logic [N-1:0]      events,
  output logic [N-1:0]      rdata,
  output logic [N-1:0]      clr_bits,
  output logic [N-1:0]      mask,
  output logic [N-1:0]      sense,
  output logic [N-1:0]      drv_val,
  output logic [N-1:0]      drv_en
);

  reg_sel_e     sel;
  logic [N-1:0] dir_q, open_q, dat_q, mask_q, sense_q;

  assign sel = decode_addr(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      open_q  <= '0;
      dat_q   <= '0;
      mask_q  <= '0;
      sense_q <= '0;
    end else if (we) begin
      case (sel)
        SEL_DIR:   dir_q   <= wdata;
        SEL_OPEN:  open_q  <= wdata;
        SEL_DATA:  dat_q   <= wdata;
        SEL_MASK:  mask_q  <= wdata;
        SEL_SENSE: sense_q <= wdata;
        default:   ;
      endcase
    end
  end

  assign clr_bits = (we && sel == SEL_EVT) ? wdata : '0;

  always_comb begin
    case (sel)
      SEL_DIR:   rdata = dir_q;
      SEL_OPEN:  rdata = open_q;
      SEL_DATA:  rdata = (dat_q & dir_q) | (level & ~dir_q);
      SEL_EVT:   rdata = events;
      SEL_MASK:  rdata = mask_q;
      SEL_SENSE: rdata = sense_q;
      default:   rdata = '0;
    endcase
  end

  // Push-pull drives the latch; open-drain drives low or releases.
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_drive
      assign drv_en[g]  = dir_q[g] & ~(open_q[g] & dat_q[g]);
      assign drv_val[g] = dat_q[g] & ~open_q[g];
    end
  endgenerate

  assign mask  = mask_q;
  assign sense = sense_q;

  // R3: an input pin is never driven
  a_r3_input_released: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en & ~dir_q) == '0);

  // R2: writes to unmapped addresses leave the configuration alone
  a_r2_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_NONE) |=> ($stable(dir_q) && $stable(dat_q) && $stable(mask_q)));

  // R9: an open-drain pin that is enabled is driving low
  a_r9_open_low: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en & open_q & drv_val) == '0);

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);

  localparam int TOP = NPINS - 1;

  // Register-order (pin n at bit TOP-n) views of the pin ports.
  logic [NPINS-1:0] in_reg, out_reg, oe_reg;
  logic [NPINS-1:0] level_w, edge_w, events_w, clr_w, mask_w, sense_w;

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_flip
      assign in_reg[TOP-g] = pin_in[g];
      assign pin_out[g]    = out_reg[TOP-g];
      assign pin_oe[g]     = oe_reg[TOP-g];
    end
  endgenerate

  gpio_sync_edge #(.N(NPINS)) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .raw          (in_reg),
    .falling_only (sense_w),
    .level        (level_w),
    .edge_hit     (edge_w)
  );

  gpio_event_reg #(.N(NPINS)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_hit (edge_w),
    .clr_bits (clr_w),
    .mask     (mask_w),
    .events   (events_w),
    .irq      (irq)
  );

  gpio_cfg_regs #(.N(NPINS)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .we       (bus_we),
    .wdata    (bus_wdata),
    .level    (level_w),
    .events   (events_w),
    .rdata    (bus_rdata),
    .clr_bits (clr_w),
    .mask     (mask_w),
    .sense    (sense_w),
    .drv_val  (out_reg),
    .drv_en   (oe_reg)
  );

  // R11: with the mask cleared no interrupt is raised
  a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_w == '0) |-> !irq);

endmodule

// File: tb/gpio_edge_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_bench;

  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [NP-1:0] bus_wdata = '0;
  logic [NP-1:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  gpio_edge_ctrl u_gpio_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  function automatic logic [NP-1:0] rev(input logic [NP-1:0] v);
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) r[i] = v[NP-1-i];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [NP-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic expect_reg(input logic [4:0] a, input logic [NP-1:0] e, input string req);
    logic [NP-1:0] v;
    rd(a, v);
    check(v === e, req, v, e);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [NP-1:0] v, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    for (int a = 0; a < 6; a++) expect_reg(5'(a*4), '0, "R10 reset reg");
    check(irq === 1'b0, "R10 irq", {31'b0, irq}, '0);
    check(pin_oe === '0, "R10 oe", pin_oe, '0);

    // R2: readback of plain registers and unmapped address
    wr(5'h04, 32'h1234_5678); expect_reg(5'h04, 32'h1234_5678, "R2 open-drain");
    wr(5'h10, 32'h0F0F_00FF); expect_reg(5'h10, 32'h0F0F_00FF, "R2 mask");
    wr(5'h14, 32'hCAFE_0001); expect_reg(5'h14, 32'hCAFE_0001, "R2 edge-control");
    wr(5'h18, 32'hFFFF_FFFF); expect_reg(5'h18, '0, "R2 unmapped read");
    expect_reg(5'h10, 32'h0F0F_00FF, "R2 unmapped write ignored");
    wr(5'h04, '0); wr(5'h10, '0); wr(5'h14, '0);

    // R3, R1: direction drives reversed output enables
    wr(5'h00, 32'h8000_00F1);
    expect_reg(5'h00, 32'h8000_00F1, "R2 direction");
    check(pin_oe === rev(32'h8000_00F1), "R3 R1 oe map", pin_oe, rev(32'h8000_00F1));
    check(pin_oe[0] === 1'b1, "R1 pin0 is msb", {31'b0, pin_oe[0]}, 32'd1);

    // R8: mixed readback
    wr(5'h00, 32'hFFFF_0000);
    wr(5'h08, 32'hA5A5_A5A5);
    pin_in = 32'h0000_3C81;
    settle();
    e = (32'hA5A5_A5A5 & 32'hFFFF_0000) | (rev(32'h0000_3C81) & 32'h0000_FFFF);
    expect_reg(5'h08, e, "R8 data readback");
    check(pin_out === rev(32'hA5A5_A5A5), "R3 R1 drive value", pin_out, rev(32'hA5A5_A5A5));

    // R9: open drain on the upper half
    wr(5'h04, 32'hFFFF_0000);
    e = rev(32'hFFFF_0000 & ~32'hA5A5_A5A5);
    check(pin_oe === e, "R9 open-drain enable", pin_oe, e);
    check((pin_out & rev(32'hFFFF_0000)) === '0, "R9 open-drain low", pin_out, '0);
    wr(5'h04, '0); wr(5'h00, '0); wr(5'h08, '0);
    pin_in = '0;
    settle();
    wr(5'h0C, '1);
    expect_reg(5'h0C, '0, "R4 clear all");

    // Sweep: every pin, both sensing modes
    for (int m = 0; m < 2; m++) begin
      wr(5'h14, m ? '1 : '0);
      for (int n = 0; n < NP; n++) begin
        logic [NP-1:0] bitv;
        bitv = 32'h8000_0000 >> n;
        wr(5'h10, bitv);
        pin_in = 32'd1 << n;
        settle();
        e = m ? '0 : bitv;
        expect_reg(5'h0C, e, m ? "R6 rise ignored" : "R6 R1 rise flagged");
        check(irq === (m == 0), "R5 irq on rise", {31'b0, irq}, {31'b0, m == 0});
        wr(5'h0C, '1);
        pin_in = '0;
        settle();
        expect_reg(5'h0C, bitv, "R6 R1 fall flagged");
        check(irq === 1'b1, "R5 irq on fall", {31'b0, irq}, 32'd1);
        wr(5'h0C, ~bitv);
        expect_reg(5'h0C, bitv, "R4 zero keeps");
        wr(5'h0C, bitv);
        expect_reg(5'h0C, '0, "R4 one clears");
        check(irq === 1'b0, "R5 irq drops", {31'b0, irq}, '0);
      end
    end
    wr(5'h14, '0);

    // R6: exact latency - not visible after two edges, visible after three
    pin_in = 32'd1 << 5;
    repeat (2) @(negedge clk);
    #1 bus_addr = 5'h0C; #1 v = bus_rdata;
    check(v === '0, "R6 latency early", v, '0);
    @(negedge clk); #1 v = bus_rdata;
    check(v === (32'h8000_0000 >> 5), "R6 latency three", v, 32'h8000_0000 >> 5);

    // R7: clear write in the same cycle as a new edge
    pin_in = '0;
    @(negedge clk); @(negedge clk);
    bus_addr = 5'h0C; bus_wdata = '1; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    expect_reg(5'h0C, 32'h8000_0000 >> 5, "R7 edge wins");

    // R5, R11: mask gating and ack-all/mask-all
    wr(5'h10, '0);
    check(irq === 1'b0, "R5 masked pending", {31'b0, irq}, '0);
    wr(5'h10, 32'h8000_0000 >> 5);
    check(irq === 1'b1, "R5 unmasked pending", {31'b0, irq}, 32'd1);
    wr(5'h0C, '1); wr(5'h10, '0);
    expect_reg(5'h0C, '0, "R11 all acked");
    check(irq === 1'b0, "R11 irq low", {31'b0, irq}, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule